// File: doc/BRIEF.md
# Serial Configuration Port with Split-Frame Readback

This block is a serial slave that loads a small bank of configuration registers. It receives 16-bit frames on a data pin, most significant bit first, while an active-low load strobe is held low. A polarity pin selects which serial clock edge samples the incoming data. The readback output changes on the other edge. All serial inputs are oversampled by the block's own system clock. The current register contents are presented on a flat parallel bus for the rest of the chip.

Bit 15 of a frame selects the operation: 0 writes and 1 reads. Bits 14..10 carry the register address and bits 9..0 carry the data. A read request does not return data in its own frame. The addressed value is shifted out on the serial output during the next 16-bit slot, so several frames can be chained while the strobe stays low. A self-clearing software-reset bit in register 0 restores every register to its default value, and so does the asynchronous hardware reset.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame is 16 bits sent MSB first. Bit 15 = 0 means write, bits 14..10 are the address and bits 9..0 the data. A completed write frame stores `data & field_mask` in the addressed register.
- R2: When `sclk_pol_i` = 1, data is sampled on the rising edge of `sclk_i` and `sdo_o` changes only on falling edges. When `sclk_pol_i` = 0, both edges are swapped.
- R3: Frames sent back to back under one low period of `sload_i` are each decoded in order.
- R4: A read request (bit 15 = 1) ignores its data bits and changes no register. In the next slot, `sdo_o` carries the word {6'b0, value} MSB first. Its MSB is valid at the second sampling edge of that slot, and bit 0 is valid after the slot's 16th launch edge.
- R5: If `sload_i` is high when the slot following a read request would begin, the readback starts in the first slot after `sload_i` next goes low.
- R6: The address map, with field mask and default for each register, is:
  - 0: control. Mask 0x380, default 0x380 (bit 9 standby_n, bit 8 clamp_off, bit 7 black_cal_en).
  - 1: gain. Mask 0x3FF, default 0.
  - 2 and 3: aux level A and B. Mask 0x1FF (bit 8 enable, bits 7..0 level), default 0.
  - 6: black reference. Mask 0x0FF, default 64.
  - 7: blank level. Mask 0x3FF, default 0.
  - 8: edge polarity select. Mask 0x01F, default 0.
  - 9: timing A. Mask 0x01F, default 0x010 (bit 4 bypass).
  - 10: timing B. Mask 0x0FF, default 0.
- R7: Writing 1 in bit 0 of register 0 restores every register to its default, whatever the other bits hold. Bit 0 always reads back as 0.
- R8: Writes to addresses 4, 5 and 11..31 change nothing, and reads from them return 0.
- R9: A frame cut short by `sload_i` rising before its 16th sampling edge is discarded without any register update.
- R10: While `rst_ni` is low, every register holds its default and `sdo_o` is 0.
- R11: `sdo_o` is 0 while `sload_i` is high and in any slot that does not carry readback data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sload_i | input | 1 | Frame strobe, active low |
| sdin_i | input | 1 | Serial data in, MSB first |
| sclk_pol_i | input | 1 | 1: sample on rising edge; 0: sample on falling edge |
| sdo_o | output | 1 | Serial readback data |
| cfg_o | output | NUM_REGS*DATA_W | Register contents; register i occupies bits [i*DATA_W +: DATA_W] |

## Verification
A serial edge becomes visible inside the block SYNC_STAGES+1 system cycles after it reaches the pin. The frame-complete pulse follows one cycle later, and `cfg_o` updates one cycle after that. A readback bit is driven one cycle after its launch edge is detected. The bench holds every serial clock phase for eight system cycles and samples `sdo_o` just before the next sampling edge, or six cycles after the final launch edge for bit 0, so each result is settled when it is read. Register contents are checked only through serial readback, against a behavioural register model held in the bench. That model follows the masks, defaults and reset rules.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int CFG_DW   = 10;
  localparam int CFG_AW   = 5;
  localparam int CFG_NREG = 11;

  function automatic logic [CFG_DW-1:0] reg_mask(input int unsigned idx);
    case (idx)
      0:       return 10'h380;
      1, 7:    return 10'h3FF;
      2, 3:    return 10'h1FF;
      6, 10:   return 10'h0FF;
      8, 9:    return 10'h01F;
      default: return '0;
    endcase
  endfunction

  function automatic logic [CFG_DW-1:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 10'h380;
      6:       return 10'h040;
      9:       return 10'h010;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sclk_edge.sv
module cfg_sclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sload_i,
  input  logic sdin_i,
  input  logic pol_i,
  output logic samp_o,
  output logic launch_o,
  output logic sload_o,
  output logic sdin_o
);
  logic [STAGES-1:0] sclk_q, sload_q, sdin_q;
  logic              sclk_d;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= '0;
      sload_q <= '1;
      sdin_q  <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_q  <= {sclk_q[STAGES-2:0], sclk_i};
      sload_q <= {sload_q[STAGES-2:0], sload_i};
      sdin_q  <= {sdin_q[STAGES-2:0], sdin_i};
      sclk_d  <= sclk_q[STAGES-1];
    end
  end

  assign rise     = sclk_q[STAGES-1] & ~sclk_d;
  assign fall     = ~sclk_q[STAGES-1] & sclk_d;
  assign samp_o   = pol_i ? rise : fall;
  assign launch_o = pol_i ? fall : rise;
  assign sload_o  = sload_q[STAGES-1];
  assign sdin_o   = sdin_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               samp_i,
  input  logic               sload_i,
  input  logic               sdin_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CW = $clog2(FRAME_W);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      frame_o <= '0;
    end else begin
      valid_o <= 1'b0;
      if (sload_i) begin
        cnt_q <= '0;  // abort partial frame
      end else if (samp_i) begin
        frame_o <= {frame_o[FRAME_W-2:0], sdin_i};
        if (cnt_q == CW'(FRAME_W-1)) begin
          cnt_q   <= '0;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int DW   = CFG_DW,
  parameter int AW   = CFG_AW,
  parameter int NREG = CFG_NREG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] cfg_o
);
  logic [DW-1:0] regs_q [NREG];
  logic          soft_rst;

  assign soft_rst = wr_i && (addr_i == '0) && data_i[0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_mask(i);
    localparam logic [DW-1:0] DEF  = reg_default(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[i] <= DEF;
      else if (soft_rst)                         regs_q[i] <= DEF;
      else if (wr_i && (addr_i == AW'(i)))       regs_q[i] <= data_i & MASK;
    end
    assign cfg_o[i*DW +: DW] = regs_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_i == AW'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/cfg_rdback_tx.sv
module cfg_rdback_tx #(
  parameter int FRAME_W = 16,
  parameter int DW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          samp_i,
  input  logic          launch_i,
  input  logic          sload_i,
  output logic          sdo_o
);
  localparam int LW = $clog2(FRAME_W+1);
  logic [FRAME_W-1:0] pend_q, shift_q;
  logic               pend_v_q, act_q;
  logic [LW-1:0]      left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      shift_q  <= '0;
      pend_v_q <= 1'b0;
      act_q    <= 1'b0;
      left_q   <= '0;
      sdo_o    <= 1'b0;
    end else begin
      if (sload_i) begin
        act_q <= 1'b0;
        sdo_o <= 1'b0;
      end else if (samp_i && pend_v_q && (!act_q || left_q == '0)) begin
        // slot boundary: pending word takes over the shifter
        shift_q  <= pend_q;
        left_q   <= LW'(FRAME_W);
        act_q    <= 1'b1;
        pend_v_q <= 1'b0;
      end else if (launch_i && act_q) begin
        if (left_q != '0) begin
          sdo_o   <= shift_q[FRAME_W-1];
          shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
          left_q  <= left_q - 1'b1;
        end else begin
          act_q <= 1'b0;
          sdo_o <= 1'b0;
        end
      end
      if (load_i) begin
        pend_q   <= {{(FRAME_W-DW){1'b0}}, load_data_i};
        pend_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int DATA_W      = CFG_DW,
  parameter int ADDR_W      = CFG_AW,
  parameter int NUM_REGS    = CFG_NREG,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sload_i,
  input  logic                     sdin_i,
  input  logic                     sclk_pol_i,
  output logic                     sdo_o,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  logic               samp_p, launch_p, sload_s, sdin_s;
  logic               frm_valid;
  logic [FRAME_W-1:0] frm_q;
  logic               frm_rd;
  logic [ADDR_W-1:0]  frm_addr;
  logic [DATA_W-1:0]  frm_data, rd_data;

  cfg_sclk_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk_i, .rst_ni, .sclk_i, .sload_i, .sdin_i,
    .pol_i(sclk_pol_i), .samp_o(samp_p), .launch_o(launch_p),
    .sload_o(sload_s), .sdin_o(sdin_s)
  );

  cfg_frame_rx #(.FRAME_W(FRAME_W)) i_rx (
    .clk_i, .rst_ni, .samp_i(samp_p), .sload_i(sload_s), .sdin_i(sdin_s),
    .valid_o(frm_valid), .frame_o(frm_q)
  );

  assign frm_rd   = frm_q[FRAME_W-1];
  assign frm_addr = frm_q[FRAME_W-2 -: ADDR_W];
  assign frm_data = frm_q[DATA_W-1:0];

  cfg_reg_bank #(.DW(DATA_W), .AW(ADDR_W), .NREG(NUM_REGS)) i_bank (
    .clk_i, .rst_ni, .wr_i(frm_valid && !frm_rd), .addr_i(frm_addr),
    .data_i(frm_data), .rd_data_o(rd_data), .cfg_o
  );

  cfg_rdback_tx #(.FRAME_W(FRAME_W), .DW(DATA_W)) i_tx (
    .clk_i, .rst_ni, .load_i(frm_valid && frm_rd), .load_data_i(rd_data),
    .samp_i(samp_p), .launch_i(launch_p), .sload_i(sload_s), .sdo_o
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_port_pkg::*;
#(
  parameter int DW   = CFG_DW,
  parameter int AW   = CFG_AW,
  parameter int NREG = CFG_NREG
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frm_valid,
  input logic [AW+DW:0]     frm_q,
  input logic               sload_s,
  input logic               launch_p,
  input logic               sdo_o,
  input logic [NREG*DW-1:0] cfg_o
);
  function automatic logic [NREG*DW-1:0] def_flat();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = reg_default(i);
    return v;
  endfunction

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid |=> $stable(cfg_o)); // R1

  AST_SDO_ON_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_p && !sload_s) |=> $stable(sdo_o)); // R2

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid && !frm_q[AW+DW] && frm_q[AW+DW-1 -: AW] == '0 && frm_q[0])
      |=> cfg_o == def_flat()); // R7

  AST_CTRL_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[0] == 1'b0); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[4*DW +: 2*DW] == '0); // R8

  AST_ABORT_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sload_s |=> !frm_valid); // R9

  AST_SDO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sload_s |=> !sdo_o); // R11
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .DW(DATA_W), .AW(ADDR_W), .NREG(NUM_REGS)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frm_valid(frm_valid), .frm_q(frm_q),
  .sload_s(sload_s), .launch_p(launch_p), .sdo_o(sdo_o), .cfg_o(cfg_o)
);

// File: tb/test_cfg_serial_port.sv
`timescale 1ns/1ps
module test_cfg_serial_port;
  localparam int HALF = 8;

  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sload = 1, sdin = 0, pol = 1;
  logic sdo;
  logic [109:0] cfg;
  int checks = 0, errors = 0;
  int exp_q [11];

  cfg_serial_port i_cfg_serial_port (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sload_i(sload),
    .sdin_i(sdin), .sclk_pol_i(pol), .sdo_o(sdo), .cfg_o(cfg)
  );

  always #10 clk = ~clk;

  // model of the register map (R6)
  function automatic int mdl_mask(int a);
    case (a)
      0: return 'h380; 1: return 'h3FF; 2: return 'h1FF; 3: return 'h1FF;
      6: return 'h0FF; 7: return 'h3FF; 8: return 'h01F; 9: return 'h01F;
      10: return 'h0FF; default: return 0;
    endcase
  endfunction
  function automatic int mdl_def(int a);
    case (a) 0: return 'h380; 6: return 64; 9: return 'h010; default: return 0; endcase
  endfunction
  task automatic mdl_reset();
    for (int i = 0; i < 11; i++) exp_q[i] = mdl_def(i);
  endtask
  task automatic mdl_write(int a, int d);
    if (a == 0 && (d & 1)) mdl_reset();
    else if (a < 11) exp_q[a] = d & mdl_mask(a);
  endtask
  function automatic int mdl_read(int a);
    return (a < 11) ? exp_q[a] : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pol(bit p);
    pol = p; sclk = p ? 1'b0 : 1'b1;
    wait_clk(HALF);
  endtask
  task automatic load_low();
    sload = 0; wait_clk(HALF);
  endtask
  task automatic load_high();
    sload = 1; wait_clk(HALF);
    check(sdo == 1'b0, "R11 sdo idle with load high", sdo, 0);
  endtask

  // one slot: sample edges 2..16 give bits 15..1, bit 0 read after last launch
  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      sdin = w[15-i];
      wait_clk(HALF);
      if (i >= 1) got[16-i] = sdo;
      sclk = ~sclk;
      wait_clk(HALF);
      sclk = ~sclk;
    end
    if (nbits == 16) begin
      wait_clk(6);
      got[0] = sdo;
    end
  endtask

  function automatic logic [15:0] wr_w(int a, int d);
    return {1'b0, 5'(a), 10'(d)};
  endfunction
  function automatic logic [15:0] rd_w(int a);
    return {1'b1, 5'(a), 10'h2AB};  // data bits ignored (R4)
  endfunction

  task automatic write_reg(int a, int d);
    logic [15:0] g;
    load_low(); xfer(wr_w(a, d), 16, g); load_high();
    mdl_write(a, d);
  endtask

  task automatic read_chk(int a, string req);
    logic [15:0] g;
    load_low();
    xfer(rd_w(a), 16, g);
    xfer(wr_w(4, 'h3FF), 16, g);  // dummy slot, reserved write (R8)
    load_high();
    check(g == 16'(mdl_read(a)), req, g, mdl_read(a));
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 11; a++) read_chk(a, req);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] g;
    mdl_reset();
    wait_clk(4);
    check(sdo == 1'b0, "R10 sdo in reset", sdo, 0);
    rst_ni = 1;
    wait_clk(4);
    set_pol(1);

    // defaults after reset (R10, R6)
    read_all("R10 R6 default after reset");

    // writes, rising-edge sampling (R1, R2, R6)
    write_reg(1, 'h2D0); write_reg(2, 'h3A5); write_reg(3, 'h1FF);
    write_reg(6, 'h3C3); write_reg(7, 'h155); write_reg(8, 'h3EA);
    write_reg(9, 'h00F); write_reg(10, 'h2F1); write_reg(0, 'h07E);
    read_all("R1 R6 masked write, rising edge");

    // reserved and unmapped (R8)
    write_reg(4, 'h3FF); write_reg(5, 'h123); write_reg(20, 'h3FF);
    read_chk(4, "R8 reserved 4 reads 0");
    read_chk(5, "R8 reserved 5 reads 0");
    read_chk(20, "R8 unmapped 20 reads 0");
    read_chk(7, "R8 mapped reg untouched");

    // back-to-back chain (R3, R4, R11)
    load_low();
    xfer(rd_w(1), 16, g);
    xfer(rd_w(6), 16, g);
    check(g == 16'(mdl_read(1)), "R3 chained read of reg 1", g, mdl_read(1));
    xfer(wr_w(7, 'h0AA), 16, g);
    check(g == 16'(mdl_read(6)), "R3 chained read of reg 6", g, mdl_read(6));
    mdl_write(7, 'h0AA);
    xfer(rd_w(7), 16, g);
    check(g == 16'h0, "R11 slot after write carries zero", g, 0);
    xfer(wr_w(4, 0), 16, g);
    check(g == 16'(mdl_read(7)), "R3 R4 write then read in chain", g, mdl_read(7));
    load_high();

    // deferred readback (R5)
    load_low(); xfer(rd_w(2), 16, g); load_high();
    wait_clk(40);
    load_low(); xfer(wr_w(5, 0), 16, g); load_high();
    check(g == 16'(mdl_read(2)), "R5 deferred readback", g, mdl_read(2));

    // aborted frame (R9)
    load_low(); xfer(wr_w(1, 'h155), 9, g); load_high();
    read_chk(1, "R9 aborted write discarded");
    load_low(); xfer(wr_w(1, 'h3FF), 15, g); load_high();
    read_chk(1, "R9 15-bit frame discarded");

    // falling-edge sampling (R2)
    set_pol(0);
    write_reg(1, 'h0F0); write_reg(10, 'h0A5); write_reg(3, 'h0C3);
    read_chk(1, "R2 falling-edge write/read gain");
    read_chk(10, "R2 falling-edge timing B");
    read_chk(3, "R2 falling-edge aux B");

    // software reset (R7)
    write_reg(0, 'h07F);
    read_all("R7 soft reset restores defaults");
    write_reg(0, 'h001);
    read_chk(0, "R7 control bit 0 self-clears");
    set_pol(1);

    // hardware reset (R10)
    write_reg(6, 'h011); write_reg(9, 'h000);
    rst_ni = 0; wait_clk(3);
    check(sdo == 1'b0, "R10 sdo low in reset", sdo, 0);
    rst_ni = 1; wait_clk(3);
    mdl_reset();
    read_chk(6, "R10 black ref default after reset");
    read_chk(9, "R10 timing A default after reset");
    read_chk(0, "R10 control default after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule